// File: doc/BRIEF.md
# MFM Write Stream Escape Interpreter

This block sits on the write path of a floppy-style disk controller, between a byte-wide FIFO loaded by DMA and the MFM bit encoder. Software does not program sector framing through registers. The byte stream itself carries inline commands, and each command starts with the escape byte 0x99. An escape sequence can do one of the following:
- produce a mark byte whose clock bit is suppressed;
- produce a mark byte with a normal clock bit;
- insert the running CRC;
- end the write;
- open a window of raw sector data in which escape recognition is switched off.

A write begins with a `start` pulse while the block is idle. After that the encoder asks for bytes by holding `enc_ready`. Each byte handed over is qualified by `out_valid`, and `out_noclk` travels with it to tell the encoder to drop that byte's clock bit. Escape bytes and command bytes are used up without producing output. While the CRC is being sent, the encoder is still served but the FIFO is not read. If the encoder needs a byte and the FIFO is empty, the write aborts with an underrun pulse.

A typical frame looks like this:
- gap bytes 0x4E;
- zero sync bytes;
- three clockless A1 marks and an FB data mark;
- a raw window of sector data;
- the CRC, some gap bytes and the stop command.

Top module: `mfm_escape_writer`

## Requirements
- R1: After reset `busy`, `out_valid`, `fifo_pop`, `done` and `underrun` are all low.
- R2: After `start` in idle, each cycle with `enc_ready` high and a non-escape byte at the FIFO head pops that byte and passes it out unchanged in the same cycle, with `out_noclk` low and input order kept.
- R3: Escape (0x99) followed by 0xA1 emits 0xA1, and escape followed by 0xC2 emits 0xC2, both with `out_noclk` high. No other emitted byte has `out_noclk` high.
- R4: Escape followed by 0xFB, 0xFE or 0xFC emits that byte with `out_noclk` low. Escape followed by 0x99 emits one literal 0x99 with `out_noclk` low.
- R5: Escape followed by 0x0F passes the next RAW_LEN bytes (default 512) out unchanged, 0x99 included. The first byte after the window is decoded normally again.
- R6: Escape followed by 0x04 emits two CRC bytes, high byte first, on the next two encoder requests without popping the FIFO. The CRC is CRC-16 with polynomial 0x1021, MSB-first. It is preset to 0xFFFF at an A1 mark that does not directly follow another emitted A1 mark. It covers every emitted byte from that mark on, except CRC bytes.
- R7: Escape followed by 0x08 raises `done` for one cycle in the cycle the 0x08 is popped, emits nothing, and `busy` is low in the next cycle.
- R8: If `busy`, `enc_ready` high, a FIFO byte needed and `fifo_empty` high, then `underrun` pulses, nothing is popped or emitted, and `busy` is low in the next cycle.
- R9: Escape followed by any byte not listed in R3 to R7 emits nothing, and decoding resumes with the following byte.
- R10: While idle, no byte is popped or emitted whatever `enc_ready` and the FIFO hold. An escape byte on its own emits nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a write frame (taken when idle) |
| fifo_data | input | 8 | Byte at the FIFO head |
| fifo_empty | input | 1 | FIFO holds no byte |
| fifo_pop | output | 1 | Remove the head byte at this edge |
| enc_ready | input | 1 | Encoder requests a byte this cycle |
| out_valid | output | 1 | Byte delivered to the encoder |
| out_byte | output | 8 | Byte for the encoder |
| out_noclk | output | 1 | Suppress the clock bit of this byte |
| busy | output | 1 | A write frame is in progress |
| done | output | 1 | Stop command consumed (pulse) |
| underrun | output | 1 | Write aborted, FIFO empty when needed (pulse) |

## Verification
The case that is hardest to reach from the ports is the boundary of the raw window. The last raw byte must be able to equal the escape code and still pass through. The byte right after it must be treated as an escape again, and the CRC that follows must be correct over all 512 random bytes. The stimulus builds complete frames in which the final raw byte is forced to 0x99 and the CRC command comes immediately after it. The encoder request is throttled at random, so CRC emission and escape consumption land on ready and stalled cycles alike. The CRC bytes are checked twice: once against a bench interpreter, and once by the zero residue left when the CRC is run over the marks, data and emitted CRC. A frame with no stop command covers underrun.

// File: rtl/mew_pkg.sv
`timescale 1ns/1ps
package mew_pkg;
  localparam logic [7:0]  ESC_BYTE   = 8'h99;
  localparam logic [7:0]  CMD_SYNC   = 8'hA1;
  localparam logic [7:0]  CMD_INDEX  = 8'hC2;
  localparam logic [7:0]  CMD_DAM    = 8'hFB;
  localparam logic [7:0]  CMD_IDAM   = 8'hFE;
  localparam logic [7:0]  CMD_IAM    = 8'hFC;
  localparam logic [7:0]  CMD_RAW    = 8'h0F;
  localparam logic [7:0]  CMD_CRC    = 8'h04;
  localparam logic [7:0]  CMD_STOP   = 8'h08;
  localparam logic [15:0] CRC_POLY   = 16'h1021;
  localparam logic [15:0] CRC_PRESET = 16'hFFFF;

  typedef enum logic [1:0] {PH_IDLE, PH_RUN, PH_CRC_HI, PH_CRC_LO} phase_t;
  typedef enum logic [2:0] {CK_NONE, CK_NOCLK, CK_PLAIN, CK_RAW, CK_CRC, CK_STOP} cmd_kind_t;

  function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {b, 8'h00};
    for (int i = 0; i < 8; i++) begin
      r = r[15] ? ((r << 1) ^ CRC_POLY) : (r << 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/mew_cmd_decode.sv
`timescale 1ns/1ps
module mew_cmd_decode
  import mew_pkg::*;
(
  input  logic [7:0] cmd,
  output cmd_kind_t  kind
);
  always_comb begin
    unique case (cmd)
      CMD_SYNC, CMD_INDEX:                  kind = CK_NOCLK;
      CMD_DAM, CMD_IDAM, CMD_IAM, ESC_BYTE: kind = CK_PLAIN;
      CMD_RAW:                              kind = CK_RAW;
      CMD_CRC:                              kind = CK_CRC;
      CMD_STOP:                             kind = CK_STOP;
      default:                              kind = CK_NONE;
    endcase
  end
endmodule

// File: rtl/mew_raw_window.sv
`timescale 1ns/1ps
module mew_raw_window #(
  parameter int RAW_LEN = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic load,
  input  logic consume,
  output logic active
);
  localparam int CW = $clog2(RAW_LEN + 1);
  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) left_q <= '0;
    else if (load)       left_q <= CW'(RAW_LEN);
    else if (consume)    left_q <= left_q - 1'b1;
  end

  assign active = (left_q != '0);

  // R5: a byte is only counted as raw inside an open window
  assert_consume_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    consume |-> active);
  // R5: the window closes only by consuming its last byte or by a clear
  assert_window_close_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> ($past(consume) || $past(clear)));
endmodule

// File: rtl/mew_crc16.sv
`timescale 1ns/1ps
module mew_crc16
  import mew_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        seed,
  input  logic        upd,
  input  logic [7:0]  data,
  output logic [15:0] crc
);
  logic [15:0] crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    crc_q <= CRC_PRESET;
    else if (seed) crc_q <= crc16_byte(CRC_PRESET, data);
    else if (upd)  crc_q <= crc16_byte(crc_q, data);
  end

  assign crc = crc_q;

  // R6: the running CRC must not move when nothing is folded in (e.g. during CRC output)
  assert_crc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(seed || upd) |=> $stable(crc));
endmodule

// File: rtl/mfm_escape_writer.sv
`timescale 1ns/1ps
module mfm_escape_writer
  import mew_pkg::*;
#(
  parameter int RAW_LEN = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] fifo_data,
  input  logic       fifo_empty,
  output logic       fifo_pop,
  input  logic       enc_ready,
  output logic       out_valid,
  output logic [7:0] out_byte,
  output logic       out_noclk,
  output logic       busy,
  output logic       done,
  output logic       underrun
);
  phase_t    phase_q, phase_d;
  logic      esc_q, esc_d;
  logic      prev_a1_q, prev_a1_d;
  cmd_kind_t kind;
  logic      raw_active;
  logic [15:0] crc;

  // named internal events
  logic need_byte, take, raw_take, esc_take, norm_take;
  logic crc_seed, crc_upd, raw_load, enter_crc, stop_evt, raw_clear, start_acc;

  mew_cmd_decode u_dec (.cmd(fifo_data), .kind(kind));

  mew_raw_window #(.RAW_LEN(RAW_LEN)) u_raw (
    .clk(clk), .rst_n(rst_n), .clear(raw_clear), .load(raw_load),
    .consume(raw_take), .active(raw_active));

  mew_crc16 u_crc (
    .clk(clk), .rst_n(rst_n), .seed(crc_seed), .upd(crc_upd),
    .data(out_byte), .crc(crc));

  assign busy      = (phase_q != PH_IDLE);
  assign start_acc = start && !busy;
  assign need_byte = (phase_q == PH_RUN) && enc_ready;
  assign take      = need_byte && !fifo_empty;
  assign underrun  = need_byte && fifo_empty;
  assign fifo_pop  = take;
  assign raw_take  = take && raw_active;
  assign esc_take  = take && !raw_active && esc_q;
  assign norm_take = take && !raw_active && !esc_q;
  assign raw_clear = start_acc || underrun || stop_evt;
  assign done      = stop_evt;

  always_comb begin
    out_valid = 1'b0;
    out_byte  = fifo_data;
    out_noclk = 1'b0;
    crc_seed  = 1'b0;
    crc_upd   = 1'b0;
    raw_load  = 1'b0;
    enter_crc = 1'b0;
    stop_evt  = 1'b0;
    esc_d     = esc_q;
    prev_a1_d = prev_a1_q;
    if (phase_q == PH_CRC_HI && enc_ready) begin
      out_valid = 1'b1;
      out_byte  = crc[15:8];
    end else if (phase_q == PH_CRC_LO && enc_ready) begin
      out_valid = 1'b1;
      out_byte  = crc[7:0];
    end else if (raw_take) begin
      out_valid = 1'b1;
      crc_upd   = 1'b1;
    end else if (norm_take) begin
      if (fifo_data == ESC_BYTE) esc_d = 1'b1;
      else begin
        out_valid = 1'b1;
        crc_upd   = 1'b1;
      end
    end else if (esc_take) begin
      esc_d = 1'b0;
      unique case (kind)
        CK_NOCLK: begin
          out_valid = 1'b1;
          out_noclk = 1'b1;
          if (fifo_data == CMD_SYNC && !prev_a1_q) crc_seed = 1'b1;
          else                                     crc_upd  = 1'b1;
        end
        CK_PLAIN: begin
          out_valid = 1'b1;
          crc_upd   = 1'b1;
        end
        CK_RAW:  raw_load  = 1'b1;
        CK_CRC:  enter_crc = 1'b1;
        CK_STOP: stop_evt  = 1'b1;
        default: ;
      endcase
    end
    if (out_valid) prev_a1_d = esc_take && out_noclk && (fifo_data == CMD_SYNC);
  end

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:   if (start) phase_d = PH_RUN;
      PH_RUN:    if (underrun || stop_evt) phase_d = PH_IDLE;
                 else if (enter_crc)       phase_d = PH_CRC_HI;
      PH_CRC_HI: if (enc_ready) phase_d = PH_CRC_LO;
      PH_CRC_LO: if (enc_ready) phase_d = PH_RUN;
      default:   phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      esc_q     <= 1'b0;
      prev_a1_q <= 1'b0;
    end else if (start_acc) begin
      phase_q   <= phase_d;
      esc_q     <= 1'b0;
      prev_a1_q <= 1'b0;
    end else begin
      phase_q   <= phase_d;
      esc_q     <= esc_d;
      prev_a1_q <= prev_a1_d;
    end
  end

  // R2: the FIFO is never read when it is empty
  assert_pop_nonempty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> !fifo_empty);
  // R2: a byte goes to the encoder only when it asks for one
  assert_out_on_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> enc_ready);
  // R3: only the two sync marks ever travel without a clock bit
  assert_noclk_marks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_noclk) |-> (out_byte == CMD_SYNC || out_byte == CMD_INDEX));
  // R6: output without a FIFO read happens only while the CRC is sent
  assert_crc_no_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !fifo_pop) |-> (phase_q == PH_CRC_HI || phase_q == PH_CRC_LO));
  // R7: stop ends the frame
  assert_done_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  // R8: underrun ends the frame and moves nothing
  assert_underrun_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> (!fifo_pop && !out_valid) ##1 !busy);
  // R10: idle is silent
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!fifo_pop && !out_valid));
endmodule

// File: tb/tb_mfm_escape_writer.sv
`timescale 1ns/1ps
module tb_mfm_escape_writer;
  localparam int RAW = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] fifo_data = 8'h00;
  logic fifo_empty = 1'b1;
  logic enc_ready = 1'b0;
  logic fifo_pop, out_valid, out_noclk, busy, done, underrun;
  logic [7:0] out_byte;

  always #10 clk = ~clk;

  mfm_escape_writer #(.RAW_LEN(RAW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .fifo_data(fifo_data),
    .fifo_empty(fifo_empty), .fifo_pop(fifo_pop), .enc_ready(enc_ready),
    .out_valid(out_valid), .out_byte(out_byte), .out_noclk(out_noclk),
    .busy(busy), .done(done), .underrun(underrun));

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [7:0] frame_q[$];
  logic [7:0] fifo_q[$];
  logic [7:0] got_b[$];
  logic       got_f[$];
  logic [7:0] exp_b[$];
  logic       exp_f[$];
  bit exp_stop, exp_under, saw_done, saw_under;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // bit-serial CRC, MSB first
  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    logic fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[15] ^ b[i];
      r  = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  // reference interpreter of the frame, written from the requirements
  task automatic model();
    int idx = 0;
    int raw_left = 0;
    bit esc = 0;
    bit pa1 = 0;
    logic [15:0] c = 16'hFFFF;
    logic [7:0] b;
    exp_b.delete(); exp_f.delete();
    exp_stop = 0; exp_under = 0;
    forever begin
      if (idx >= frame_q.size()) begin exp_under = 1; break; end
      b = frame_q[idx]; idx++;
      if (raw_left > 0) begin
        exp_b.push_back(b); exp_f.push_back(0); c = ref_crc(c, b); pa1 = 0; raw_left--;
      end else if (esc) begin
        esc = 0;
        if (b == 8'hA1) begin
          exp_b.push_back(b); exp_f.push_back(1);
          c = pa1 ? ref_crc(c, b) : ref_crc(16'hFFFF, b); pa1 = 1;
        end else if (b == 8'hC2) begin
          exp_b.push_back(b); exp_f.push_back(1); c = ref_crc(c, b); pa1 = 0;
        end else if (b == 8'hFB || b == 8'hFE || b == 8'hFC || b == 8'h99) begin
          exp_b.push_back(b); exp_f.push_back(0); c = ref_crc(c, b); pa1 = 0;
        end else if (b == 8'h0F) begin
          raw_left = RAW;
        end else if (b == 8'h04) begin
          exp_b.push_back(c[15:8]); exp_f.push_back(0);
          exp_b.push_back(c[7:0]);  exp_f.push_back(0);
          pa1 = 0;
        end else if (b == 8'h08) begin
          exp_stop = 1; break;
        end
      end else if (b == 8'h99) begin
        esc = 1;
      end else begin
        exp_b.push_back(b); exp_f.push_back(0); c = ref_crc(c, b); pa1 = 0;
      end
    end
  endtask

  task automatic add(input logic [7:0] b); frame_q.push_back(b); endtask
  task automatic add_esc(input logic [7:0] b); add(8'h99); add(b); endtask

  task automatic build_std(input int gaps);
    frame_q.delete();
    for (int i = 0; i < gaps; i++) add(8'h4E);
    for (int i = 0; i < 6; i++) add(8'h00);
    for (int i = 0; i < 3; i++) add_esc(8'hA1);
    add_esc(8'hFB);
    add_esc(8'h0F);
    for (int i = 0; i < RAW - 1; i++) add(($urandom % 8 == 0) ? 8'h99 : 8'($urandom));
    add(8'h99);                      // last raw byte equals the escape code
    add_esc(8'h04);
    add(8'h4E); add(8'h4E);
    add_esc(8'h08);
  endtask

  task automatic run_frame(input string tag);
    bit pop_pend = 0;
    fifo_q = frame_q;
    got_b.delete(); got_f.delete();
    saw_done = 0; saw_under = 0;
    @(negedge clk);
    enc_ready = 0; start = 1;
    fifo_empty = (fifo_q.size() == 0);
    fifo_data  = fifo_q.size() ? fifo_q[0] : 8'h00;
    @(negedge clk);
    start = 0;
    for (int cyc = 0; cyc < 8000; cyc++) begin
      if (cyc > 0) @(negedge clk);
      if (pop_pend) void'(fifo_q.pop_front());
      fifo_empty = (fifo_q.size() == 0);
      fifo_data  = fifo_q.size() ? fifo_q[0] : 8'h00;
      enc_ready  = (($urandom % 10) < 7);
      #1;
      pop_pend = fifo_pop;
      if (out_valid) begin got_b.push_back(out_byte); got_f.push_back(out_noclk); end
      if (done) saw_done = 1;
      if (underrun) saw_under = 1;
      if (done || underrun) break;
    end
    @(negedge clk);
    enc_ready = 0;
    #1;
    model();
    check(got_b.size() == exp_b.size(), "R2", {tag, " byte count"}, got_b.size(), exp_b.size());
    begin
      int bad = -1;
      int n = (got_b.size() < exp_b.size()) ? got_b.size() : exp_b.size();
      for (int i = 0; i < n; i++)
        if (bad < 0 && (got_b[i] !== exp_b[i] || got_f[i] !== exp_f[i])) bad = i;
      if (bad >= 0)
        check(0, "R3", {tag, " stream byte/flag at index"}, {got_f[bad], got_b[bad]},
              {exp_f[bad], exp_b[bad]});
      else
        check(1, "R4", {tag, " stream"}, 0, 0);
    end
    check(saw_done == exp_stop, "R7", {tag, " done"}, saw_done, exp_stop);
    check(saw_under == exp_under, "R8", {tag, " underrun"}, saw_under, exp_under);
    check(busy == 0, "R7", {tag, " busy after end"}, busy, 0);
  endtask

  // residue over A1 A1 A1 FB + raw data + CRC pair must be zero
  task automatic residue_check(input string tag);
    int a = -1;
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < got_b.size(); i++)
      if (a < 0 && got_f[i] && got_b[i] == 8'hA1) a = i;
    if (a < 0 || a + 4 + RAW + 2 > got_b.size()) begin
      check(0, "R6", {tag, " CRC frame located"}, a, 0);
    end else begin
      for (int i = a; i < a + 4 + RAW + 2; i++) c = ref_crc(c, got_b[i]);
      check(c == 16'h0000, "R6", {tag, " CRC residue"}, c, 0);
      check(got_b[a + 4 + RAW - 1] == 8'h99, "R5", {tag, " last raw byte"}, got_b[a + 4 + RAW - 1], 8'h99);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1;
    fifo_empty = 0; fifo_data = 8'h55; enc_ready = 1;
    #1;
    check(busy == 0 && out_valid == 0 && fifo_pop == 0 && done == 0 && underrun == 0,
          "R1", "reset outputs", {busy, out_valid, fifo_pop, done, underrun}, 0);
    // R10: idle with data and requests moves nothing
    begin
      bit moved = 0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk); #1;
        if (fifo_pop || out_valid) moved = 1;
      end
      check(!moved, "R10", "idle quiet", moved, 0);
    end
    enc_ready = 0;

    build_std(8);  run_frame("std1");  residue_check("std1");
    build_std(3);  run_frame("std2");  residue_check("std2");

    // marks, literal escape, unknown command (R9), index mark
    frame_q.delete();
    for (int i = 0; i < 3; i++) add_esc(8'hC2);
    add_esc(8'hFC);
    add(8'h4E); add(8'h4E);
    for (int i = 0; i < 3; i++) add_esc(8'hA1);
    add_esc(8'hFE);
    add(8'h03); add(8'h00); add(8'h01); add(8'h02);
    add_esc(8'h04);
    add_esc(8'h55);   // R9: unknown command dropped
    add_esc(8'h99);   // R4: literal escape
    add(8'h4E);
    add_esc(8'h08);
    run_frame("marks");

    // R8: no stop command, FIFO runs dry
    frame_q.delete();
    add_esc(8'hA1); add(8'h12); add(8'h99);  // dangling escape at the end
    run_frame("underrun");

    // R8: dry inside the raw window
    frame_q.delete();
    add_esc(8'h0F);
    for (int i = 0; i < 20; i++) add(8'($urandom));
    run_frame("rawdry");

    // random short frames of non-escape bytes (R2)
    for (int k = 0; k < 3; k++) begin
      frame_q.delete();
      for (int i = 0; i < 30; i++) begin
        logic [7:0] b = 8'($urandom);
        if (b == 8'h99) b = 8'h98;
        add(b);
      end
      add_esc(8'h08);
      run_frame("plain");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(150000 * 20);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule